// File: doc/BRIEF.md
# Receive Frame FIFO with Status Trailer

This block sits between a receive MAC and a host on an Ethernet-style receive path. The MAC pushes 32-bit double words for a frame. It then gives a single end strobe that carries the frame's condition flags, a discard request and the count of valid bytes in the last word. For every frame it keeps, the block writes one extra double word after the data. This trailer packs the frame's byte count in its upper half and its status in its lower half. A frame that is discarded is wound back completely. A frame becomes visible to the host only once its trailer has been written.

The host pops words in order. When the host pops a trailer, the block compares the number of data words it has handed out since the previous trailer with the count implied by the trailer's byte count. On a mismatch it flags the trailer and flushes the whole receive section. A separate 8-bit status register latches the status of each frame for the host and clears when read. While it holds unread status it keeps that status.

Top module: `rxq_frame_fifo`

## Requirements
- R1: After reset `rd_valid` is low and `stat` is 0.
- R2: Data words leave on `rd_data` in the order written. A frame's words become visible only in the cycle after its end strobe. `rd_en` while `rd_valid` is low changes nothing.
- R3: A kept frame is followed by one trailer word with `rd_trailer` high. Bits 31:16 hold the byte count, which is 4 times the number of data words received, less (4 - `wr_tail`) when `wr_tail` is nonzero (0 for an empty frame). Bits 15:9 are zero. A cycle with `wr_end` high stores no data word.
- R4: Trailer bits 6:0 are: bit 6 byte count of at least 12, bit 5 `end_good`, bit 4 `end_oversize`, bit 3 `end_short`, bit 2 `end_dribble`, bit 1 `end_crc`, bit 0 overflow. Bit 7 is set when `abort_pulse` was high together with `csel` between the first data word and the end strobe.
- R5: A frame ended with `end_discard` high leaves no word on the read side, and later frames are unaffected.
- R6: A data word that arrives while DEPTH-1 or more entries are occupied is dropped and sets overflow (bit 0) for the frame. The byte count still counts the dropped words.
- R7: Trailer bit 8 reads high when the data words popped since the previous trailer differ from ceil(byte count / 4), and low otherwise.
- R8: Popping a trailer with bit 8 high empties the FIFO at that clock edge. Any frame being received at that edge is dropped in full up to its end strobe.
- R9: At each end strobe, unless `stat` bit 7 is held unread, `stat` takes bit 7 = 1 and bits 6:0 of that frame's status, in the cycle after the strobe. A read in the same cycle frees the register for the new status.
- R10: A `stat_rd` pulse clears `stat` in the next cycle. While bit 7 is set and no read occurs, `stat` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Data word present on `wr_data` |
| wr_data | input | 32 | Receive data double word |
| wr_end | input | 1 | End-of-frame strobe |
| wr_tail | input | 2 | Valid bytes in the last data word, 0 meaning 4 |
| end_good | input | 1 | Frame received good |
| end_oversize | input | 1 | Frame longer than allowed |
| end_short | input | 1 | Frame shorter than allowed |
| end_dribble | input | 1 | Frame ended off a byte boundary |
| end_crc | input | 1 | Frame check sequence wrong |
| end_discard | input | 1 | Drop this frame instead of keeping it |
| abort_pulse | input | 1 | Receive abort request |
| csel | input | 1 | Chip select qualifying the abort |
| rd_en | input | 1 | Pop the word on `rd_data` |
| rd_valid | output | 1 | A committed word is available |
| rd_data | output | 32 | Head word, with bit 8 of a trailer carrying the read check |
| rd_trailer | output | 1 | Head word is a trailer |
| stat_rd | input | 1 | Host read of the status register |
| stat | output | 8 | Receive status register |

## Verification
The hardest state to reach from the ports is the read-error self reset with a new frame half written. On a sound write path, the stored word count and the byte count agree. The stimulus therefore keeps a frame that overflowed. Its byte count counts the dropped words, so the trailer disagrees with what is read. The bench drains that frame, starts the next frame, and pops the flagged trailer in the same cycle as a data write. It then confirms that the FIFO is empty, that the rest of the interrupted frame never appears, and that the frame after it reads back intact.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int DATA_W = 32;
   localparam int BC_W   = 16;
   localparam int WCNT_W = BC_W - 2;
   localparam int ENT_W  = DATA_W + 1;
   localparam int TR_BAD_BIT = 8;

   // frame length in bytes from words received and tail byte count
   function automatic logic [BC_W-1:0] byte_total(input logic [WCNT_W-1:0] w,
                                                  input logic [1:0] t);
      logic [BC_W-1:0] trim;
      trim = (t == 2'd0) ? '0 : BC_W'(3'd4 - {1'b0, t});
      if (w == '0) return '0;
      return {w, 2'b00} - trim;
   endfunction

   // double words implied by a byte count (rounded up)
   function automatic logic [BC_W-1:0] words_of(input logic [BC_W-1:0] b);
      logic [BC_W+1:0] s;
      s = {2'b00, b} + (BC_W+2)'(3);
      return s[BC_W+1:2];
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int AW = 4,
   parameter int W  = 33
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
   import rxq_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             srst,
   input  logic             wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic             wr_end,
   input  logic [1:0]       wr_tail,
   input  logic [4:0]       cond_i,
   input  logic             end_discard,
   input  logic             abort_pulse,
   input  logic             csel,
   input  logic [AW:0]      rptr_i,
   output logic             we_o,
   output logic [AW-1:0]    waddr_o,
   output logic [ENT_W-1:0] wdata_o,
   output logic [AW:0]      cptr_o,
   output logic [6:0]       end_stat_o
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] ROOM_LIM = (AW+1)'(DEPTH - 1);

   logic [AW:0]       wptr_q, cptr_q, used;
   logic [WCNT_W-1:0] wcnt_q;
   logic              ovf_q, abrt_q, inframe_q, purge_q;
   logic              room, acc, store, keep, abrt_now;
   logic [BC_W-1:0]   bytes;
   logic [6:0]        st;

   always_comb begin
      used     = wptr_q - rptr_i;
      room     = used < ROOM_LIM;
      acc      = wr_valid & ~wr_end & ~purge_q;
      store    = acc & room;
      keep     = wr_end & ~end_discard & ~purge_q;
      abrt_now = abort_pulse & csel & (inframe_q | (wr_valid & ~wr_end));
      bytes    = byte_total(wcnt_q, wr_tail);
      st       = {(bytes >= BC_W'(12)), cond_i, ovf_q};
      we_o     = store | keep;
      waddr_o  = wptr_q[AW-1:0];
      wdata_o  = keep ? {1'b1, bytes, 7'd0, 1'b0, (abrt_q | abrt_now), st}
                      : {1'b0, wr_data};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q    <= '0;
         cptr_q    <= '0;
         wcnt_q    <= '0;
         ovf_q     <= 1'b0;
         abrt_q    <= 1'b0;
         inframe_q <= 1'b0;
         purge_q   <= 1'b0;
      end else if (srst) begin
         wptr_q    <= '0;
         cptr_q    <= '0;
         wcnt_q    <= '0;
         ovf_q     <= 1'b0;
         abrt_q    <= 1'b0;
         inframe_q <= 1'b0;
         purge_q   <= (inframe_q | wr_valid | purge_q) & ~wr_end;
      end else begin
         if (store) wptr_q <= wptr_q + 1'b1;
         if (acc) begin
            if (wcnt_q != '1) wcnt_q <= wcnt_q + 1'b1;
            if (!room) ovf_q <= 1'b1;
         end
         if (wr_end) begin
            if (keep) begin
               wptr_q <= wptr_q + 1'b1;
               cptr_q <= wptr_q + 1'b1;
            end else begin
               wptr_q <= cptr_q;
            end
            wcnt_q    <= '0;
            ovf_q     <= 1'b0;
            abrt_q    <= 1'b0;
            inframe_q <= 1'b0;
            purge_q   <= 1'b0;
         end else begin
            if (wr_valid) inframe_q <= 1'b1;
            if (abrt_now) abrt_q <= 1'b1;
         end
      end
   end

   assign cptr_o     = cptr_q;
   assign end_stat_o = st;
endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl
   import rxq_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [AW:0]       cptr_i,
   input  logic [ENT_W-1:0]  rword_i,
   output logic [AW-1:0]     raddr_o,
   output logic [AW:0]       rptr_o,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_trailer,
   output logic              srst_o
);
   logic [AW:0]     rptr_q;
   logic [BC_W-1:0] rcnt_q;
   logic            bad, pop;

   always_comb begin
      rd_valid   = rptr_q != cptr_i;
      rd_trailer = rd_valid & rword_i[DATA_W];
      bad        = rd_trailer & (rcnt_q != words_of(rword_i[DATA_W-1:DATA_W-BC_W]));
      rd_data    = rd_valid ? (rword_i[DATA_W-1:0] | (DATA_W'(bad) << TR_BAD_BIT)) : '0;
      pop        = rd_en & rd_valid;
      srst_o     = pop & bad;
   end

   always_ff @(posedge clk) begin
      if (rst || srst_o) begin
         rptr_q <= '0;
         rcnt_q <= '0;
      end else if (pop) begin
         rptr_q <= rptr_q + 1'b1;
         rcnt_q <= rd_trailer ? '0 : rcnt_q + 1'b1;
      end
   end

   assign raddr_o = rptr_q[AW-1:0];
   assign rptr_o  = rptr_q;
endmodule

// File: rtl/rxq_frame_fifo.sv
module rxq_frame_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_valid,
   input  logic [31:0] wr_data,
   input  logic        wr_end,
   input  logic [1:0]  wr_tail,
   input  logic        end_good,
   input  logic        end_oversize,
   input  logic        end_short,
   input  logic        end_dribble,
   input  logic        end_crc,
   input  logic        end_discard,
   input  logic        abort_pulse,
   input  logic        csel,
   input  logic        rd_en,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        rd_trailer,
   input  logic        stat_rd,
   output logic [7:0]  stat
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("rxq_frame_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [AW:0]      rptr, cptr;
   logic [AW-1:0]    waddr, raddr;
   logic [ENT_W-1:0] wdata, rword;
   logic             we, srst;
   logic [6:0]       end_stat;
   logic [7:0]       stat_q;

   rxq_wr_ctrl #(.AW(AW)) u_wr (
      .clk(clk), .rst(rst), .srst(srst),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_end(wr_end), .wr_tail(wr_tail),
      .cond_i({end_good, end_oversize, end_short, end_dribble, end_crc}),
      .end_discard(end_discard), .abort_pulse(abort_pulse), .csel(csel),
      .rptr_i(rptr), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
      .cptr_o(cptr), .end_stat_o(end_stat)
   );

   rxq_store #(.AW(AW), .W(ENT_W)) u_mem (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rword)
   );

   rxq_rd_ctrl #(.AW(AW)) u_rd (
      .clk(clk), .rst(rst), .rd_en(rd_en), .cptr_i(cptr), .rword_i(rword),
      .raddr_o(raddr), .rptr_o(rptr), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_trailer(rd_trailer), .srst_o(srst)
   );

   // host status register: latch on frame end unless unread status is held
   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= '0;
      end else if (wr_end && !(stat_q[7] && !stat_rd)) begin
         stat_q <= {1'b1, end_stat};
      end else if (stat_rd) begin
         stat_q <= '0;
      end
   end

   assign stat = stat_q;
endmodule

// File: rtl/rxq_frame_fifo_chk.sv
module rxq_frame_fifo_chk (
   input logic        clk,
   input logic        rst,
   input logic        wr_end,
   input logic        end_discard,
   input logic        rd_en,
   input logic        rd_valid,
   input logic [31:0] rd_data,
   input logic        rd_trailer,
   input logic        stat_rd,
   input logic [7:0]  stat
);
   // R2
   no_early_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_valid && !wr_end) |=> !rd_valid);

   // R3
   trailer_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
      rd_trailer |-> (rd_data[15:9] == 7'd0));

   // R5
   discard_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_end && end_discard && !rd_valid) |=> !rd_valid);

   // R8
   selfrst_flush_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_trailer && rd_data[8]) |=> !rd_valid);

   // R9
   stat_newflag_chk: assert property (@(posedge clk) disable iff (rst)
      (stat != 8'd0) |-> stat[7]);

   // R10
   stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && !wr_end) |=> (stat == 8'd0));

   // R10
   stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stat[7] && !stat_rd) |=> $stable(stat));
endmodule

bind rxq_frame_fifo rxq_frame_fifo_chk u_chk (.*);

// File: tb/rxq_frame_fifo_bench.sv
module rxq_frame_fifo_bench;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst = 1'b1;
   logic        wr_valid = 0, wr_end = 0, end_good = 0, end_oversize = 0;
   logic        end_short = 0, end_dribble = 0, end_crc = 0, end_discard = 0;
   logic        abort_pulse = 0, csel = 0, rd_en = 0, stat_rd = 0;
   logic [31:0] wr_data = '0;
   logic [1:0]  wr_tail = '0;
   logic        rd_valid, rd_trailer;
   logic [31:0] rd_data;
   logic [7:0]  stat;

   int checks = 0, errors = 0;

   rxq_frame_fifo #(.DEPTH(DEPTH)) u_rxq_frame_fifo (.*);

   // behavioural reference
   logic [32:0] mq[$];
   logic [32:0] mp[$];
   int   mw = 0, mrc = 0;
   bit   mov = 0, mab = 0, mfr = 0, mpg = 0;
   logic [7:0] mst = '0;

   function automatic bit head_bad();
      if (mq.size() == 0) return 0;
      return mq[0][32] && (mrc != (int'(mq[0][31:16]) + 3) / 4);
   endfunction

   always @(posedge clk) begin
      int used, bytes;
      bit pop, srst, abn;
      logic [6:0] st7;
      logic [7:0] base;
      logic [32:0] f;
      if (rst) begin
         mq.delete(); mp.delete();
         mw = 0; mrc = 0; mov = 0; mab = 0; mfr = 0; mpg = 0; mst = '0;
      end else begin
         used  = mq.size() + mp.size();
         pop   = rd_en && mq.size() > 0;
         srst  = pop && head_bad();
         bytes = (mw == 0) ? 0 : mw * 4 - ((wr_tail != 0) ? 4 - int'(wr_tail) : 0);
         st7   = {bytes >= 12, end_good, end_oversize, end_short, end_dribble, end_crc, mov};
         abn   = abort_pulse && csel && (mfr || (wr_valid && !wr_end));
         base  = stat_rd ? 8'd0 : mst;
         mst   = (wr_end && !base[7]) ? {1'b1, st7} : base;
         if (srst) begin
            mq.delete(); mp.delete();
            mrc = 0; mw = 0; mov = 0; mab = 0;
            mpg = (mfr || wr_valid || mpg) && !wr_end;
            mfr = 0;
         end else begin
            if (pop) begin
               f = mq.pop_front();
               mrc = f[32] ? 0 : mrc + 1;
            end
            if (wr_end) begin
               if (!end_discard && !mpg) begin
                  mp.push_back({1'b1, 16'(bytes), 7'd0, 1'b0, mab | abn, st7});
                  foreach (mp[i]) mq.push_back(mp[i]);
               end
               mp.delete();
               mw = 0; mov = 0; mab = 0; mfr = 0; mpg = 0;
            end else begin
               if (wr_valid && !mpg) begin
                  if (mw < 16383) mw++;
                  if (used < DEPTH - 1) mp.push_back({1'b0, wr_data});
                  else mov = 1;
               end
               if (wr_valid) mfr = 1;
               if (abn) mab = 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic [31:0] e;
      bit ev;
      ev = mq.size() > 0;
      check(rd_valid === ev, "R2 rd_valid vs model", 32'(rd_valid), 32'(ev));
      if (ev) begin
         e = mq[0][31:0] | (32'(head_bad()) << 8);
         check(rd_data === e, mq[0][32] ? "R3 trailer vs model" : "R2 data vs model", rd_data, e);
         check(rd_trailer === mq[0][32], "R3 rd_trailer vs model", 32'(rd_trailer), 32'(mq[0][32]));
      end
      check(stat === mst, "R9 stat vs model", 32'(stat), 32'(mst));
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   task automatic send(input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         wr_valid = 1; wr_data = base + 32'(i);
         tick();
      end
      wr_valid = 0;
   endtask

   task automatic finish_frame(input logic [1:0] tail, input logic [4:0] c, input bit disc);
      wr_end = 1; wr_tail = tail;
      {end_good, end_oversize, end_short, end_dribble, end_crc} = c;
      end_discard = disc;
      tick();
      wr_end = 0; end_discard = 0;
      {end_good, end_oversize, end_short, end_dribble, end_crc} = '0;
   endtask

   task automatic pop();
      rd_en = 1; tick(); rd_en = 0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst = 0;
      tick();
      // R1
      check(rd_valid === 1'b0, "R1 empty after reset", 32'(rd_valid), 0);
      check(stat === 8'd0, "R1 status after reset", 32'(stat), 0);

      // R2 pop on empty has no effect
      pop();
      send(3, 32'hA000_0000);
      check(rd_valid === 1'b0, "R2 not visible before end", 32'(rd_valid), 0);
      finish_frame(2'd2, 5'b10000, 0);
      check(stat === 8'hA0, "R9 status latched", 32'(stat), 32'hA0);
      check(rd_data === 32'hA000_0000, "R2 first word", rd_data, 32'hA000_0000);
      pop();
      check(rd_data === 32'hA000_0001, "R2 second word", rd_data, 32'hA000_0001);
      pop(); pop();
      check(rd_trailer === 1'b1, "R3 trailer flag", 32'(rd_trailer), 1);
      check(rd_data === 32'h000A_0020, "R3 R4 R7 trailer 10 bytes good", rd_data, 32'h000A_0020);
      pop();
      check(rd_valid === 1'b0, "R2 drained", 32'(rd_valid), 0);

      // R4 abort with select, status held (R10)
      wr_valid = 1; wr_data = 32'hB000_0000; tick();
      abort_pulse = 1; csel = 1; wr_data = 32'hB000_0001; tick();
      abort_pulse = 0; csel = 0; wr_valid = 0;
      send(2, 32'hB000_0002);
      finish_frame(2'd0, 5'b00011, 0);
      check(stat === 8'hA0, "R10 unread status held", 32'(stat), 32'hA0);
      stat_rd = 1; tick(); stat_rd = 0;
      check(stat === 8'h00, "R10 cleared by read", 32'(stat), 0);
      repeat (4) pop();
      check(rd_data === 32'h0010_00C6, "R4 trailer crc dribble abort", rd_data, 32'h0010_00C6);
      pop();

      // R4 abort without select is ignored
      wr_valid = 1; wr_data = 32'hC000_0000; abort_pulse = 1; csel = 0; tick();
      wr_valid = 0; abort_pulse = 0;
      finish_frame(2'd0, 5'b10000, 0);
      check(stat === 8'hA0, "R9 latched after clear", 32'(stat), 32'hA0);
      pop();
      check(rd_data === 32'h0004_0020, "R4 abort ignored without select", rd_data, 32'h0004_0020);
      pop();

      // R5 discard
      send(3, 32'hD000_0000);
      finish_frame(2'd0, 5'b00001, 1);
      check(rd_valid === 1'b0, "R5 discarded frame absent", 32'(rd_valid), 0);
      send(1, 32'hD100_0000);
      finish_frame(2'd1, 5'b10000, 0);
      check(rd_data === 32'hD100_0000, "R5 next frame intact", rd_data, 32'hD100_0000);
      pop();
      check(rd_data === 32'h0001_0020, "R3 one byte frame", rd_data, 32'h0001_0020);
      pop();
      stat_rd = 1; tick(); stat_rd = 0;

      // R6 overflow, R7 mismatch, R8 self reset
      send(20, 32'hE000_0000);
      finish_frame(2'd0, 5'b00000, 0);
      repeat (14) pop();
      check(rd_data === 32'hE000_000E, "R6 last stored word", rd_data, 32'hE000_000E);
      pop();
      check(rd_data === 32'h0050_0141, "R6 R7 overflow trailer flagged", rd_data, 32'h0050_0141);
      send(2, 32'hF000_0000);
      wr_valid = 1; wr_data = 32'hF000_0002; rd_en = 1; tick();
      rd_en = 0; wr_valid = 0;
      check(rd_valid === 1'b0, "R8 flushed on bad trailer", 32'(rd_valid), 0);
      send(2, 32'hF000_0003);
      finish_frame(2'd0, 5'b10000, 0);
      check(rd_valid === 1'b0, "R8 interrupted frame dropped", 32'(rd_valid), 0);
      send(2, 32'h9000_0000);
      finish_frame(2'd0, 5'b10000, 0);
      check(rd_data === 32'h9000_0000, "R8 recovered", rd_data, 32'h9000_0000);
      pop(); pop();
      check(rd_data === 32'h0008_0020, "R7 clean after recovery", rd_data, 32'h0008_0020);
      pop();
      repeat (2) tick();
      summary();
      $finish;
   end
endmodule